// File: doc/BRIEF.md
# Fractional Baud Generator with Oversampling Select

This block derives the two timing strobes that one UART channel needs from the system clock. The first is an oversample tick that paces the receive and transmit samplers. The second is a per-bit strobe that marks every bit boundary. The tick period is an integer divisor plus a fraction counted in sixteenths. The fraction is realised by lengthening some tick periods by one system clock, and these lengthened periods are spread evenly across each group of sixteen ticks. The bit strobe fires on every 16th, 8th or 4th tick. Choosing a smaller oversampling ratio therefore raises the highest reachable bit rate by two or four times.

Software programs the block through a byte-wide write port and a combinational read port. There is a low divisor byte, a high divisor byte, a fraction/ratio byte and a feature-gate byte. The fraction/ratio byte can be changed only while the gate bit is set. Every write that changes a divisor setting restarts all counting, so a new rate begins on a clean boundary.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the integer divisor, fraction and ratio code all read back as zero, the gate bit reads back as zero, and neither tick nor strobe is produced.
- R2: Address 0 holds the low byte and address 1 the high byte of the integer divisor D = {high, low}. Both read back what was written.
- R3: At address 2, bits [3:0] hold the fraction F and bits [5:4] hold the ratio code. Bits [7:6] are not stored and read back as zero.
- R4: At address 3 only bit 4, the gate, is stored. It reads back at bit 4 and all other bits read as zero.
- R5: A write to address 2 while the gate is clear changes nothing: the stored value and the tick timing are unchanged.
- R6: With D > 0, tick number k (k = 0, 1, ...) counted from the last reload has a period of D + floor(((k mod 16)+1)·F/16) − floor((k mod 16)·F/16) system clocks. The first period is measured from the clock edge that took the reloading write. Each tick is high for one cycle.
- R7: As a consequence of R6, exactly F of every 16 consecutive periods after a reload are one clock longer, and the first m of them contain floor(m·F/16) long periods.
- R8: The bit strobe is high only in a tick cycle. It fires on the 16th, 8th or 4th tick after a reload and every 16, 8 or 4 ticks after that, for ratio codes 00, 01 and 10.
- R9: Ratio code 11 behaves as code 00, giving a strobe every 16 ticks.
- R10: With D = 0, neither tick nor strobe is produced.
- R11: A write to address 0 or 1, or an accepted write to address 2, restarts the period count, the fraction phase and the tick count toward the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| os_tick | output | 1 | One-cycle oversample tick |
| bit_strobe | output | 1 | One-cycle per-bit strobe, coincident with a tick |

## Verification
Two events can fall in the same cycle. A reloading write can land in the very cycle in which a tick, and possibly a strobe, is due. A tick and a bit strobe can also coincide. The bench provokes the first case by rewriting the divisor while ticks are running. It judges the result by requiring that the tick after the write arrives exactly one full new period after the write edge, and that the next strobe waits for a complete ratio count. For the second case, every tick is checked for whether it must carry the strobe, and every cycle without a tick is checked to have no strobe.

// File: rtl/bgen_pkg.sv
package bgen_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DIV_LO = 2'd0;
    localparam logic [ADDR_W-1:0] A_DIV_HI = 2'd1;
    localparam logic [ADDR_W-1:0] A_FRAC   = 2'd2;
    localparam logic [ADDR_W-1:0] A_GATE   = 2'd3;

    localparam int GATE_BIT = 4;
    localparam int OSR_LSB  = 4;

    typedef enum logic [1:0] {
        OSR_X16 = 2'b00,
        OSR_X8  = 2'b01,
        OSR_X4  = 2'b10,
        OSR_RSV = 2'b11
    } osr_e;
endpackage

// File: rtl/bgen_regs.sv
module bgen_regs
    import bgen_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic [DIV_W-1:0]  div_o,
    output logic [FRAC_W-1:0] frac_o,
    output osr_e              osr_o,
    output logic              reload_o
);
    localparam int HI_W = DIV_W - BYTE_W;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [FRAC_W-1:0] frac;
        osr_e              osr;
        logic              gate;
    } regs_t;

    regs_t cur_q, cur_d;
    logic  reload_d;

    always_comb begin
        cur_d    = cur_q;
        reload_d = 1'b0;
        if (wr_en_i) begin
            unique case (wr_addr_i)
                A_DIV_LO: begin
                    cur_d.div[BYTE_W-1:0] = wr_data_i;
                    reload_d              = 1'b1;
                end
                A_DIV_HI: begin
                    cur_d.div[DIV_W-1:BYTE_W] = wr_data_i[HI_W-1:0];
                    reload_d                  = 1'b1;
                end
                A_FRAC: begin
                    if (cur_q.gate) begin
                        cur_d.frac = wr_data_i[FRAC_W-1:0];
                        cur_d.osr  = osr_e'(wr_data_i[OSR_LSB+1:OSR_LSB]);
                        reload_d   = 1'b1;
                    end
                end
                default: begin
                    cur_d.gate = wr_data_i[GATE_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{div: '0, frac: '0, osr: OSR_X16, gate: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            A_DIV_LO: rd_data_o = cur_q.div[BYTE_W-1:0];
            A_DIV_HI: rd_data_o[HI_W-1:0] = cur_q.div[DIV_W-1:BYTE_W];
            A_FRAC: begin
                rd_data_o[FRAC_W-1:0]          = cur_q.frac;
                rd_data_o[OSR_LSB+1:OSR_LSB]   = cur_q.osr;
            end
            default: rd_data_o[GATE_BIT] = cur_q.gate;
        endcase
    end

    assign div_o    = cur_q.div;
    assign frac_o   = cur_q.frac;
    assign osr_o    = cur_q.osr;
    assign reload_o = reload_d;

    AST_GATED_FRAC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_FRAC && !cur_q.gate)
        |=> ($stable(cur_q.frac) && $stable(cur_q.osr)))
        else $error("gated fraction write took effect"); // R5
endmodule

// File: rtl/bgen_tick.sv
module bgen_tick #(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              reload_i,
    output logic              tick_o
);
    localparam int CNT_W = DIV_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } tick_t;

    tick_t st_q, st_d;
    logic [FRAC_W-1:0] acc_sum;
    logic              stretch;
    logic [CNT_W-1:0]  period;
    logic              running;

    always_comb begin
        {stretch, acc_sum} = {1'b0, st_q.acc} + {1'b0, frac_i};
        period  = {1'b0, div_i} + {{DIV_W{1'b0}}, stretch};
        running = (div_i != '0);
        tick_o  = running && (st_q.cnt == period - 1'b1);

        st_d = st_q;
        if (reload_i || !running) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
            st_d.acc = acc_sum;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= {1'b0, div_i})
        else $error("period counter past divisor"); // R6

    AST_RELOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> (st_q.cnt == '0 && st_q.acc == '0))
        else $error("reload did not restart period"); // R11
endmodule

// File: rtl/bgen_bitdiv.sv
module bgen_bitdiv
    import bgen_pkg::*;
#(
    parameter int MAX_OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  osr_e osr_i,
    input  logic reload_i,
    output logic strobe_o
);
    localparam int BC_W = $clog2(MAX_OSR);

    typedef struct packed {
        logic [BC_W-1:0] bcnt;
    } bit_t;

    bit_t            st_q, st_d;
    logic [BC_W-1:0] last;

    always_comb begin
        unique case (osr_i)
            OSR_X8:  last = BC_W'(MAX_OSR / 2 - 1);
            OSR_X4:  last = BC_W'(MAX_OSR / 4 - 1);
            default: last = BC_W'(MAX_OSR - 1);
        endcase

        strobe_o = tick_i && (st_q.bcnt == last);

        st_d = st_q;
        if (reload_i) begin
            st_d.bcnt = '0;
        end else if (tick_i) begin
            st_d.bcnt = strobe_o ? '0 : st_q.bcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STROBE_WITH_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> tick_i)
        else $error("strobe outside a tick"); // R8

    AST_BCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bcnt <= last)
        else $error("tick count past ratio"); // R9
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import bgen_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int FRAC_W  = 4,
    parameter int MAX_OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       os_tick,
    output logic       bit_strobe
);
    logic [DIV_W-1:0]  div_w;
    logic [FRAC_W-1:0] frac_w;
    osr_e              osr_w;
    logic              reload_w;

    bgen_regs #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .div_o     (div_w),
        .frac_o    (frac_w),
        .osr_o     (osr_w),
        .reload_o  (reload_w)
    );

    bgen_tick #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_i    (div_w),
        .frac_i   (frac_w),
        .reload_i (reload_w),
        .tick_o   (os_tick)
    );

    bgen_bitdiv #(.MAX_OSR(MAX_OSR)) u_bitdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (os_tick),
        .osr_i    (osr_w),
        .reload_i (reload_w),
        .strobe_o (bit_strobe)
    );

    AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (div_w == '0) |-> (!os_tick && !bit_strobe))
        else $error("output with zero divisor"); // R10
endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       os_tick;
    logic       bit_strobe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    frac_baud_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .os_tick    (os_tick),
        .bit_strobe (bit_strobe)
    );

    always #4 clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd_check(logic [1:0] a, int exp, string req);
        @(negedge clk);
        rd_addr = a;
        #1 check(rd_data == 8'(exp), req, rd_data, exp);
    endtask

    function automatic int ratio_of(int code);
        return (code == 1) ? 8 : (code == 2) ? 4 : 16;
    endfunction

    function automatic int exp_period(int d, int f, int k);
        int p = k % 16;
        return d + ((p + 1) * f) / 16 - (p * f) / 16;
    endfunction

    // program a full rate; the last write (high byte) is the reload edge
    task automatic setup(int d, int f, int code);
        wr(2'd3, 8'h10);
        wr(2'd2, 8'((code << 4) | f));
        wr(2'd0, 8'(d & 8'hFF));
        wr(2'd1, 8'(d >> 8));
    endtask

    // counts negedges from the last reload edge / previous tick
    task automatic run_ticks(int d, int f, int r, int n, string req);
        for (int k = 0; k < n; k++) begin
            int gap = 0;
            int ep  = exp_period(d, f, k);
            bit sb;
            do begin
                @(negedge clk);
                gap++;
                if (bit_strobe && !os_tick)
                    check(1'b0, "R8 strobe without tick", 1, 0);
            end while (!os_tick && gap < d + 3);
            check(gap == ep, req, gap, ep);
            sb = (((k + 1) % r) == 0);
            check(bit_strobe == sb, "R8 strobe position", bit_strobe, sb);
        end
    endtask

    task automatic quiet(int cycles, string req);
        int seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (os_tick || bit_strobe) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            check(1'b0, "watchdog", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2718);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_check(2'd0, 0, "R1 low divisor");
        rd_check(2'd1, 0, "R1 high divisor");
        rd_check(2'd2, 0, "R1 fraction/ratio");
        rd_check(2'd3, 0, "R1 gate");
        quiet(60, "R1 no output after reset");

        // R2 divisor bytes read back
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h3C);
        rd_check(2'd0, 8'hA5, "R2 low byte");
        rd_check(2'd1, 8'h3C, "R2 high byte");

        // R4 only gate bit stored
        wr(2'd3, 8'hFF);
        rd_check(2'd3, 8'h10, "R4 gate only");

        // R3 reserved bits dropped, R9 code 11 acts as 16x
        wr(2'd2, 8'hFF);
        rd_check(2'd2, 8'h3F, "R3 reserved bits zero");
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd0);
        run_ticks(3, 15, 16, 34, "R9 code 11 period");

        // R5 gated write ignored
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h1A);
        rd_check(2'd2, 0, "R5 gated write readback");
        wr(2'd0, 8'd4);
        run_ticks(4, 0, 16, 20, "R5 timing unchanged");

        // R6/R7/R8 directed per ratio
        setup(2, 8, 0);
        run_ticks(2, 8, 16, 34, "R7 half fraction");
        setup(1, 1, 1);
        run_ticks(1, 1, 8, 34, "R6 divisor one");
        setup(5, 0, 2);
        run_ticks(5, 0, 4, 20, "R8 ratio 4x");
        setup(300, 7, 1);
        run_ticks(300, 7, 8, 18, "R6 large divisor");

        // R11 reload mid-stream, also coincident with pending tick
        setup(5, 3, 0);
        run_ticks(5, 3, 16, 7, "R6 pre-reload");
        repeat (4) @(negedge clk);
        wr(2'd0, 8'd3);
        run_ticks(3, 3, 16, 20, "R11 restart after divisor write");
        setup(4, 0, 1);
        run_ticks(4, 0, 8, 3, "R6 pre-reload");
        repeat (3) @(negedge clk);
        wr(2'd1, 8'd0);
        run_ticks(4, 0, 8, 10, "R11 restart on tick cycle");

        // R10 zero divisor
        wr(2'd0, 8'd0);
        wr(2'd1, 8'd0);
        quiet(100, "R10 zero divisor silent");

        // constrained random
        for (int i = 0; i < 10; i++) begin
            int d = 1 + int'($urandom % 6);
            int f = int'($urandom % 16);
            int c = int'($urandom % 4);
            setup(d, f, c);
            run_ticks(d, f, ratio_of(c), 40, "R6 random rate");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule